// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five hardware interrupt requests the core services next. One source cannot be masked. Three restart sources each have a fixed vector address. The last source is a general request whose vector the core must fetch from outside, using an acknowledge strobe. The block holds the edge-triggered requests, applies the per-source masks and a global enable, and waits for the core to signal an instruction boundary. It then picks the highest-priority eligible source.

In the cycle after the boundary is sampled, the block reports the winner for exactly one cycle. The report carries a source code and a vector address. For the general source it instead gives an external-fetch flag together with an acknowledge pulse. Accepting any maskable source clears the global enable. The core sets it again when it is ready to take more interrupts. Pushing the return address and jumping to the vector are the core's work and are not part of this block.

All inputs are assumed to be synchronous to `clk`.

Top module: `prio_vec_intc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `take_o`, `ack_o`, `ext_o` and `en_o` are 0, and `src_o` and `vec_o` are 0.
- R2: `take_o` is high only in the cycle after a clock edge at which `boundary_i` was high and at least one source was eligible. It stays high for one cycle for each such edge.
- R3: The non-maskable source ignores `en_o` and `mask_i`. It wins over every other source and reports `src_o`=1 with `vec_o`=0x0024.
- R4: The non-maskable request is armed only by a low-to-high change on `nmi_i`, and it is dropped if `nmi_i` is low again before the boundary. A level that stays high triggers only once.
- R5: The priority order from highest to lowest is: non-maskable, restart-high (`src_o`=2), restart-mid (`src_o`=3), restart-low (`src_o`=4), general (`src_o`=5).
- R6: The restart vectors are 0x003C for restart-high, 0x0034 for restart-mid and 0x002C for restart-low.
- R7: Restart-high is edge triggered. A rising edge on `vec_hi_i` is held even after the input falls, and even while that source is masked or disabled. The held request clears when the source is accepted or when `vec_hi_clr_i` is pulsed.
- R8: Restart-mid, restart-low and general are level sensitive. A request that goes away before the boundary is not serviced.
- R9: `mask_i` bit 2 masks restart-high, bit 1 masks restart-mid and bit 0 masks restart-low; a 1 masks. The general source is not affected by `mask_i`.
- R10: `en_o` gates every source except the non-maskable one. `en_set_i` sets it and `en_clr_i` clears it, each taking effect at the next edge.
- R11: Accepting a maskable source clears `en_o` at the same edge that raises `take_o`. This clear wins over `en_set_i`. Accepting the non-maskable source leaves `en_o` unchanged.
- R12: When the general source is accepted, `ext_o` and `ack_o` are both 1 for the single `take_o` cycle and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary and can accept |
| nmi_i | input | 1 | Non-maskable request |
| vec_hi_i | input | 1 | Restart-high request (edge) |
| vec_mid_i | input | 1 | Restart-mid request (level) |
| vec_lo_i | input | 1 | Restart-low request (level) |
| gen_i | input | 1 | General request (level) |
| mask_i | input | 3 | Per-restart masks: bit 2 high, bit 1 mid, bit 0 low |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| vec_hi_clr_i | input | 1 | Discard the held restart-high request |
| take_o | output | 1 | One-cycle acceptance report |
| src_o | output | 3 | Accepted source code (0 none, 1..5) |
| vec_o | output | 16 | Vector address of the accepted source |
| ext_o | output | 1 | Vector must be fetched externally |
| ack_o | output | 1 | Acknowledge strobe for the general source |
| en_o | output | 1 | Global enable state |

## Verification
The hardest situation to reach is a restart-high edge that arrives while that source is masked and disabled, after which the input falls again. Its held state cannot be seen at the ports until both the mask and the enable are lifted. The stimulus pulses `vec_hi_i` under a mask, first lets a lower source win an arbitration, and only then unmasks. It then checks that the held request still wins and is gone after service. A second pulse is discarded with the clear input before any boundary. The non-maskable edge-plus-level rule is reached by a one-cycle pulse that falls before the boundary.

// File: rtl/intc_pkg.sv
// Shared definitions for the prioritized vectored interrupt controller.
// Assumes nothing beyond the source ordering used by the arbiter.
package intc_pkg;
    // Number of request sources, index 0 is the highest priority.
    localparam int NSRC = 5;
    localparam int SRCW = $clog2(NSRC + 1);

    typedef enum logic [SRCW-1:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_HI   = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;
endpackage

// File: rtl/intc_edge_latch.sv
// Rising-edge request holder.
// Sets a pending flag on a low-to-high change of req_i and clears it on clr_i.
// With DROP_ON_LOW=1 the flag is also dropped whenever req_i is low, so a request
// counts only while the input is still high. Assumes req_i is synchronous to clk.
module intc_edge_latch #(
    parameter bit DROP_ON_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic pend_d;

    // Next pending state: a clear wins over a new edge.
    always_comb begin
        pend_d = pend_q;
        if (req_i && !prev_q) pend_d = 1'b1;
        if (clr_i)            pend_d = 1'b0;
        if (DROP_ON_LOW && !req_i) pend_d = 1'b0;
    end

    // Register the input history and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    generate
        if (DROP_ON_LOW) begin : g_drop
            // R4: a low input never leaves a request pending
            a_r4_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
                !req_i |=> !pend_o);
        end else begin : g_hold
            // R7: a held request survives until a clear
            a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && !clr_i) |=> pend_o);
        end
    endgenerate
endmodule

// File: rtl/intc_prio_sel.sv
// Fixed-priority selector.
// Grants the lowest-index asserted bit of elig_i, where index 0 is the highest
// priority. Purely combinational.
module intc_prio_sel #(
    parameter int N = 5
) (
    input  logic [N-1:0] elig_i,
    output logic [N-1:0] grant_o
);
    logic [N:0] taken;

    // Walk from the highest priority downward; one grant at most.
    assign taken[0] = 1'b0;
    generate
        for (genvar i = 0; i < N; i++) begin : g_sel
            assign grant_o[i]  = elig_i[i] && !taken[i];
            assign taken[i+1]  = taken[i] || elig_i[i];
        end
    endgenerate

    // R5: never more than one winner
    always_comb begin
        a_r5_single_grant: assert ($onehot0(grant_o));
    end
endmodule

// File: rtl/intc_gate_en.sv
// Global interrupt enable flag.
// Set and clear come from the core; auto_clr_i (a maskable acceptance) wins over
// both. Resets to disabled.
module intc_gate_en (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic auto_clr_i,
    output logic en_o
);
    logic en_q;

    // Update the enable: acceptance clear, then core clear, then core set.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (auto_clr_i) en_q <= 1'b0;
        else if (clr_i)      en_q <= 1'b0;
        else if (set_i)      en_q <= 1'b1;
    end

    assign en_o = en_q;

    // R11: an acceptance always leaves the enable off
    a_r11_auto_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        auto_clr_i |=> !en_o);
endmodule

// File: rtl/prio_vec_intc.sv
// Prioritized vectored interrupt controller (top).
// Holds and masks five requests and arbitrates them when boundary_i is high.
// It reports the winner for one cycle, either with a fixed vector or with an
// external-fetch flag and an acknowledge pulse. Assumes all inputs are synchronous.
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int          AW      = 16,
    parameter logic [15:0] VEC_NMI = 16'h0024,
    parameter logic [15:0] VEC_HI  = 16'h003C,
    parameter logic [15:0] VEC_MID = 16'h0034,
    parameter logic [15:0] VEC_LO  = 16'h002C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary_i,
    input  logic          nmi_i,
    input  logic          vec_hi_i,
    input  logic          vec_mid_i,
    input  logic          vec_lo_i,
    input  logic          gen_i,
    input  logic [2:0]    mask_i,
    input  logic          en_set_i,
    input  logic          en_clr_i,
    input  logic          vec_hi_clr_i,
    output logic          take_o,
    output logic [2:0]    src_o,
    output logic [AW-1:0] vec_o,
    output logic          ext_o,
    output logic          ack_o
    ,
    output logic          en_o
);
    localparam int I_NMI = 0;
    localparam int I_HI  = 1;
    localparam int I_MID = 2;
    localparam int I_LO  = 3;
    localparam int I_GEN = 4;

    logic            nmi_pend;
    logic            hi_pend;
    logic            en;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] grant;
    logic            fire;
    logic            fire_mask;
    src_e            win_src;
    logic [AW-1:0]   win_vec;

    // Non-maskable request: an edge arms it, and a low level drops it.
    intc_edge_latch #(.DROP_ON_LOW(1'b1)) u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (nmi_i),
        .clr_i  (boundary_i && grant[I_NMI]),
        .pend_o (nmi_pend)
    );

    // Restart-high request: edge held until it is serviced or discarded.
    intc_edge_latch #(.DROP_ON_LOW(1'b0)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (vec_hi_i),
        .clr_i  ((boundary_i && grant[I_HI]) || vec_hi_clr_i),
        .pend_o (hi_pend)
    );

    // Global enable with auto-clear on a maskable acceptance.
    intc_gate_en u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (en_set_i),
        .clr_i      (en_clr_i),
        .auto_clr_i (fire_mask),
        .en_o       (en)
    );

    // Eligibility of each source after masking and gating.
    always_comb begin
        elig[I_NMI] = nmi_pend && nmi_i;
        elig[I_HI]  = hi_pend   && !mask_i[2] && en;
        elig[I_MID] = vec_mid_i && !mask_i[1] && en;
        elig[I_LO]  = vec_lo_i  && !mask_i[0] && en;
        elig[I_GEN] = gen_i && en;
    end

    intc_prio_sel #(.N(NSRC)) u_sel (
        .elig_i  (elig),
        .grant_o (grant)
    );

    assign fire      = boundary_i && (|grant);
    assign fire_mask = boundary_i && (|grant[NSRC-1:1]);

    // Encode the winning source and its vector.
    always_comb begin
        win_src = SRC_NONE;
        win_vec = '0;
        unique case (1'b1)
            grant[I_NMI]: begin win_src = SRC_NMI; win_vec = AW'(VEC_NMI); end
            grant[I_HI]:  begin win_src = SRC_HI;  win_vec = AW'(VEC_HI);  end
            grant[I_MID]: begin win_src = SRC_MID; win_vec = AW'(VEC_MID); end
            grant[I_LO]:  begin win_src = SRC_LO;  win_vec = AW'(VEC_LO);  end
            grant[I_GEN]: begin win_src = SRC_GEN; win_vec = '0;           end
            default:      begin win_src = SRC_NONE; win_vec = '0;          end
        endcase
    end

    // Register the one-cycle acceptance report.
    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            take_o <= 1'b0;
            src_o  <= SRC_NONE;
            vec_o  <= '0;
            ext_o  <= 1'b0;
            ack_o  <= 1'b0;
        end else begin
            take_o <= 1'b1;
            src_o  <= win_src;
            vec_o  <= win_vec;
            ext_o  <= grant[I_GEN];
            ack_o  <= grant[I_GEN];
        end
    end

    assign en_o = en;

    // R2: a report only follows a boundary
    a_r2_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));
    // R3: an armed, still-high non-maskable request at a boundary always wins
    a_r3_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && nmi_pend && nmi_i) |=> (take_o && src_o == SRC_NMI && vec_o == AW'(VEC_NMI)));
    // R11: a maskable report comes with the enable already off
    a_r11_en_off_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o != SRC_NMI) |-> !en_o);
    // R12: the acknowledge strobe only accompanies a general acceptance
    a_r12_ack_with_general: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (take_o && ext_o && src_o == SRC_GEN && vec_o == '0));
    // R1: nothing is reported right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!take_o && !ack_o && !en_o));
endmodule

// File: tb/sim_prio_vec_intc.sv
// Scoreboard bench: the arbitration task queues the expected report and the
// monitor compares it in the cycle after the boundary.
module sim_prio_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        nmi = 1'b0, hi = 1'b0, mid = 1'b0, lo = 1'b0, gen = 1'b0;
    logic [2:0]  mask = 3'b000;
    logic        en_set = 1'b0, en_clr = 1'b0, hi_clr = 1'b0;
    logic        take, ext, ack, en;
    logic [2:0]  src;
    logic [15:0] vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        take;
        logic [2:0]  src;
        logic [15:0] vec;
        logic        ext;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic  bnd_q = 1'b0;

    always #10 clk = ~clk;

    prio_vec_intc u0 (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary),
        .nmi_i(nmi), .vec_hi_i(hi), .vec_mid_i(mid), .vec_lo_i(lo), .gen_i(gen),
        .mask_i(mask), .en_set_i(en_set), .en_clr_i(en_clr), .vec_hi_clr_i(hi_clr),
        .take_o(take), .src_o(src), .vec_o(vec), .ext_o(ext), .ack_o(ack), .en_o(en)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic en_pulse();
        @(negedge clk) en_set = 1'b1;
        @(negedge clk) en_set = 1'b0;
    endtask

    // Driver: raise the boundary for one edge and queue the expected report.
    task automatic arb(bit t, logic [2:0] s, logic [15:0] v, bit x, string tag);
        exp_t e;
        @(negedge clk);
        e.take = t; e.src = s; e.vec = v; e.ext = x;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    // Remember which edges saw a boundary.
    always @(posedge clk) bnd_q <= boundary;

    // Monitor: compare the report in the cycle after a boundary edge.
    always @(negedge clk) begin
        if (bnd_q && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " take"}, 32'(take), 32'(e.take));
            check({t, " src"},  32'(src),  32'(e.src));
            check({t, " vec"},  32'(vec),  32'(e.vec));
            check({t, " ext"},  32'(ext),  32'(e.ext));
            check({t, " ack"},  32'(ack),  32'(e.ext & e.take));
        end else if (!bnd_q) begin
            check("R2 idle take", 32'(take), 32'd0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 take", 32'(take), 32'd0);
        check("R1 en",   32'(en),   32'd0);
        check("R1 vec",  32'(vec),  32'd0);
        rst_n = 1'b1;
        tick(1);
        check("R1 ack after release", 32'(ack), 32'd0);

        // R3: non-maskable source wins while everything is masked and disabled
        mask = 3'b111;
        nmi = 1'b1; tick(2);
        arb(1, 3'd1, 16'h0024, 0, "R3 nmi masked+disabled");
        // R4: a held level does not retrigger
        arb(0, 3'd0, 16'h0000, 0, "R4 nmi level no retrigger");
        // R4: a pulse that falls before the boundary is dropped
        nmi = 1'b0; tick(1); nmi = 1'b1; tick(1); nmi = 1'b0; tick(2);
        arb(0, 3'd0, 16'h0000, 0, "R4 nmi dropped");

        // R5/R6: mid beats low and general
        mask = 3'b000;
        mid = 1'b1; lo = 1'b1; gen = 1'b1;
        en_pulse();
        check("R10 en set", 32'(en), 32'd1);
        arb(1, 3'd3, 16'h0034, 0, "R5 R6 mid wins");
        check("R11 en auto clear", 32'(en), 32'd0);
        // R10: disabled means nothing maskable is taken
        arb(0, 3'd0, 16'h0000, 0, "R10 disabled");
        // R5/R6: low wins once mid is gone
        mid = 1'b0; en_pulse();
        arb(1, 3'd4, 16'h002C, 0, "R5 R6 low wins");
        // R9/R12: low masked by bit 0, so general is taken externally
        mask = 3'b001; en_pulse();
        arb(1, 3'd5, 16'h0000, 1, "R9 R12 general");
        lo = 1'b0;

        // R7: a high edge held under its mask while the input falls
        mask = 3'b100;
        hi = 1'b1; tick(1); hi = 1'b0; tick(2);
        en_pulse();
        arb(1, 3'd5, 16'h0000, 1, "R9 high masked general");
        mask = 3'b000; en_pulse();
        arb(1, 3'd2, 16'h003C, 0, "R7 R6 held high");
        en_pulse();
        arb(1, 3'd5, 16'h0000, 1, "R7 cleared by service");

        // R7: the clear input discards a held high edge
        gen = 1'b0;
        hi = 1'b1; tick(1); hi = 1'b0; tick(1);
        hi_clr = 1'b1; tick(1); hi_clr = 1'b0;
        en_pulse();
        arb(0, 3'd0, 16'h0000, 0, "R7 discarded");
        check("R10 en kept", 32'(en), 32'd1);

        // R8: a level request gone before the boundary
        lo = 1'b1; tick(1); lo = 1'b0; tick(1);
        arb(0, 3'd0, 16'h0000, 0, "R8 level gone");

        // R10: clear input disables
        @(negedge clk) en_clr = 1'b1;
        @(negedge clk) en_clr = 1'b0;
        mid = 1'b1;
        arb(0, 3'd0, 16'h0000, 0, "R10 cleared");
        mid = 1'b0;

        // R3/R5/R11: simultaneous non-maskable and high
        en_pulse();
        nmi = 1'b1; hi = 1'b1; tick(1); hi = 1'b0; tick(1);
        arb(1, 3'd1, 16'h0024, 0, "R3 nmi over high");
        check("R11 nmi keeps en", 32'(en), 32'd1);
        nmi = 1'b0;
        arb(1, 3'd2, 16'h003C, 0, "R5 high next");
        check("R11 en clear after high", 32'(en), 32'd0);

        tick(2);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule